// File: doc/BRIEF.md
# Stimulus Replay and Response Latency Monitor

This block sits in a test harness in front of a network under test. Before a run, a set of input vectors is written into a small on-chip store through a load port. On a start pulse the block presents those vectors to the network one at a time, in load order, and wraps back to the first vector when it runs out. Each vector is offered for a single cycle on a valid/data pair. The next vector follows only after the network has answered the previous one and a programmable number of idle cycles has passed, so the idle count sets how often requests are issued.

For every request the block counts the cycles from the issue cycle to the cycle in which the network raises its response-valid strobe. It keeps a count of answered requests and a running total of their latencies. Once the configured number of requests has been answered, a sequential divider forms the truncated mean latency and the block flags completion. If an answer does not arrive within a configured number of cycles, the block raises a timeout flag and stops the run.

Top module: `stim_lat_mon`

## Requirements
- R1: After reset, stim_valid, busy, done and timeout are 0, and fifo_level, req_count, lat_total and avg_lat are 0.
- R2: While idle, each cycle with ld_valid high appends ld_data to the store and raises fifo_level by one, up to DEPTH entries; further writes to a full store are dropped. A cycle with ld_clr high empties the store (fifo_level becomes 0).
- R3: While busy is high, ld_valid and ld_clr have no effect: fifo_level and the stored vectors are unchanged.
- R4: A start pulse while idle, with fifo_level nonzero and run_len nonzero, makes busy high and stim_valid high for exactly one cycle in the cycle after the pulse. A start with run_len equal to 0 or an empty store is ignored.
- R5: Request n of a run (counting from 0) carries stored vector n modulo fifo_level, where vector 0 is the first one written after the last clear.
- R6: A new request is never issued while an answer is outstanding. After an answer is accepted in cycle t, the next stim_valid pulse falls in cycle t + rate_idle + 1, leaving exactly rate_idle idle cycles.
- R7: The latency of a request is the number of cycles from its issue cycle to the answer cycle (1 if resp_valid is high in the cycle right after issue). Each accepted answer adds one to req_count and the latency to lat_total, visible in the cycle after the answer.
- R8: resp_valid is ignored unless a request is outstanding: in the issue cycle itself, in idle gaps between requests and while idle it changes neither the counts nor the issue timing.
- R9: If the latency of an outstanding request reaches tmo_cycles without an answer, timeout goes high and busy goes low in the following cycle, and no further request is issued. An answer in the cycle where the latency equals tmo_cycles is still accepted.
- R10: After run_len answers, done goes high and busy low within ACC_W + 4 cycles, with avg_lat equal to lat_total divided by req_count, rounded down.
- R11: done, timeout, req_count, lat_total and avg_lat hold their values until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_valid | input | 1 | Append ld_data to the vector store |
| ld_data | input | DATA_W | Vector to be stored |
| ld_clr | input | 1 | Empty the vector store |
| rate_idle | input | RATE_W | Idle cycles between an answer and the next issue, taken at start |
| run_len | input | CNT_W | Number of answered requests in a run, taken at start |
| tmo_cycles | input | LAT_W | Latency limit for one request, taken at start |
| start | input | 1 | Begin a run |
| stim_valid | output | 1 | One-cycle request strobe toward the network |
| stim_data | output | DATA_W | Vector presented with stim_valid |
| resp_valid | input | 1 | Answer strobe from the network |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished and average valid |
| timeout | output | 1 | Run stopped on a missing answer |
| fifo_level | output | $clog2(DEPTH)+1 | Number of stored vectors |
| req_count | output | CNT_W | Answered requests in this run |
| lat_total | output | ACC_W | Sum of latencies in this run |
| avg_lat | output | LAT_W | Truncated mean latency |

## Verification
The assertions assume that resp_valid can arrive in any cycle and that configuration ports matter only in the start cycle, so they check timing relations (one-cycle strobes, a stable store during a run, count steps of at most one, no issue after a stop) rather than exact values. The stimulus answers each request after a randomly chosen delay from 1 to 10 cycles, includes the one-cycle boundary, and adds stray answers in issue and gap cycles that must be ignored. Run lengths exceed the number of stored vectors so that replay wraps, idle counts range from 0 upward, and a directed run places one answer exactly at the latency limit and then withholds the next.

// File: rtl/slm_pkg.sv
package slm_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ISSUE = 3'd1,
    SQ_WAIT  = 3'd2,
    SQ_GAP   = 3'd3,
    SQ_DGO   = 3'd4,
    SQ_DWAIT = 3'd5
  } sq_state_e;
endpackage

// File: rtl/slm_vec_store.sv
module slm_vec_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int LVL_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              rd_rst,
  input  logic              rd_adv,
  output logic [DATA_W-1:0] rd_data,
  output logic [LVL_W-1:0]  level,
  output logic              level_nz
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0]  level_q, level_d;
  logic [ADDR_W-1:0] rd_q, rd_d;
  logic              do_wr;
  logic [LVL_W-1:0]  rd_inc;

  assign do_wr  = wr_en && !clr && (level_q != LVL_W'(DEPTH));
  assign rd_inc = LVL_W'(rd_q) + LVL_W'(1);

  always_comb begin
    level_d = level_q;
    if (clr)        level_d = '0;
    else if (do_wr) level_d = level_q + LVL_W'(1);
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_rst)      rd_d = '0;
    else if (rd_adv) rd_d = (rd_inc >= level_q) ? '0 : rd_inc[ADDR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[level_q[ADDR_W-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      rd_q    <= '0;
    end else begin
      level_q <= level_d;
      rd_q    <= rd_d;
    end
  end

  assign rd_data  = mem[rd_q];
  assign level    = level_q;
  assign level_nz = (level_q != '0);
endmodule

// File: rtl/slm_avg_div.sv
module slm_avg_div #(
  parameter int NUM_W = 40,
  parameter int DEN_W = 16,
  parameter int OUT_W = 24,
  localparam int STEP_W = $clog2(NUM_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [OUT_W-1:0] quot,
  output logic             fin
);
  logic [DEN_W:0]    rem_q, rem_d;
  logic [NUM_W-1:0]  q_q, q_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic              run_q, run_d;
  logic              fin_q, fin_d;
  logic [DEN_W:0]    rem_sh;
  logic              take;

  assign rem_sh = {rem_q[DEN_W-1:0], q_q[NUM_W-1]};
  assign take   = (rem_sh >= {1'b0, den});

  always_comb begin
    rem_d  = rem_q;
    q_d    = q_q;
    step_d = step_q;
    run_d  = run_q;
    fin_d  = 1'b0;
    if (go) begin
      rem_d  = '0;
      q_d    = num;
      step_d = STEP_W'(NUM_W);
      run_d  = 1'b1;
    end else if (run_q) begin
      rem_d  = take ? (rem_sh - {1'b0, den}) : rem_sh;
      q_d    = {q_q[NUM_W-2:0], take};
      step_d = step_q - STEP_W'(1);
      if (step_q == STEP_W'(1)) begin
        run_d = 1'b0;
        fin_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      step_q <= '0;
      run_q  <= 1'b0;
      fin_q  <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      q_q    <= q_d;
      step_q <= step_d;
      run_q  <= run_d;
      fin_q  <= fin_d;
    end
  end

  assign quot = q_q[OUT_W-1:0];
  assign fin  = fin_q;
endmodule

// File: rtl/slm_sequencer.sv
module slm_sequencer
  import slm_pkg::*;
#(
  parameter int RATE_W = 8,
  parameter int CNT_W  = 16,
  parameter int LAT_W  = 24,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] rate_idle,
  input  logic [CNT_W-1:0]  run_len,
  input  logic [LAT_W-1:0]  tmo_cycles,
  input  logic              level_nz,
  input  logic              resp_valid,
  input  logic              div_fin,
  input  logic [LAT_W-1:0]  div_quot,
  output logic              issue,
  output logic              rd_rst,
  output logic              rd_adv,
  output logic              div_go,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [CNT_W-1:0]  req_count,
  output logic [ACC_W-1:0]  lat_total,
  output logic [LAT_W-1:0]  avg_lat
);
  sq_state_e         st_q, st_d;
  logic [RATE_W-1:0] rate_q, rate_d, gap_q, gap_d;
  logic [CNT_W-1:0]  len_q, len_d, cnt_q, cnt_d;
  logic [LAT_W-1:0]  tmo_q, tmo_d, lat_q, lat_d, avg_q, avg_d;
  logic [ACC_W-1:0]  tot_q, tot_d;
  logic              done_q, done_d, tmo_f_q, tmo_f_d;
  logic [CNT_W-1:0]  cnt_inc;
  logic              go_ok;

  assign go_ok   = start && level_nz && (run_len != '0);
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    st_d    = st_q;
    rate_d  = rate_q;
    gap_d   = gap_q;
    len_d   = len_q;
    cnt_d   = cnt_q;
    tmo_d   = tmo_q;
    lat_d   = lat_q;
    avg_d   = avg_q;
    tot_d   = tot_q;
    done_d  = done_q;
    tmo_f_d = tmo_f_q;
    rd_rst  = 1'b0;
    rd_adv  = 1'b0;
    div_go  = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (go_ok) begin
          st_d    = SQ_ISSUE;
          rate_d  = rate_idle;
          len_d   = run_len;
          tmo_d   = tmo_cycles;
          cnt_d   = '0;
          tot_d   = '0;
          avg_d   = '0;
          done_d  = 1'b0;
          tmo_f_d = 1'b0;
          rd_rst  = 1'b1;
        end
      end
      SQ_ISSUE: begin
        lat_d  = LAT_W'(1);
        rd_adv = 1'b1;
        st_d   = SQ_WAIT;
      end
      SQ_WAIT: begin
        if (resp_valid) begin
          tot_d = tot_q + ACC_W'(lat_q);
          cnt_d = cnt_inc;
          if (cnt_inc == len_q) begin
            st_d = SQ_DGO;
          end else if (rate_q == '0) begin
            st_d = SQ_ISSUE;
          end else begin
            gap_d = RATE_W'(1);
            st_d  = SQ_GAP;
          end
        end else if (lat_q >= tmo_q) begin
          tmo_f_d = 1'b1;
          st_d    = SQ_IDLE;
        end else begin
          lat_d = lat_q + LAT_W'(1);
        end
      end
      SQ_GAP: begin
        if (gap_q == rate_q) st_d = SQ_ISSUE;
        else                 gap_d = gap_q + RATE_W'(1);
      end
      SQ_DGO: begin
        div_go = 1'b1;
        st_d   = SQ_DWAIT;
      end
      SQ_DWAIT: begin
        if (div_fin) begin
          avg_d  = div_quot;
          done_d = 1'b1;
          st_d   = SQ_IDLE;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      rate_q  <= '0;
      gap_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      tmo_q   <= '0;
      lat_q   <= '0;
      avg_q   <= '0;
      tot_q   <= '0;
      done_q  <= 1'b0;
      tmo_f_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      rate_q  <= rate_d;
      gap_q   <= gap_d;
      len_q   <= len_d;
      cnt_q   <= cnt_d;
      tmo_q   <= tmo_d;
      lat_q   <= lat_d;
      avg_q   <= avg_d;
      tot_q   <= tot_d;
      done_q  <= done_d;
      tmo_f_q <= tmo_f_d;
    end
  end

  assign issue     = (st_q == SQ_ISSUE);
  assign busy      = (st_q != SQ_IDLE);
  assign done      = done_q;
  assign timeout   = tmo_f_q;
  assign req_count = cnt_q;
  assign lat_total = tot_q;
  assign avg_lat   = avg_q;
endmodule

// File: rtl/stim_lat_mon.sv
module stim_lat_mon #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  parameter int RATE_W = 8,
  parameter int CNT_W  = 16,
  parameter int LAT_W  = 24,
  parameter int ACC_W  = 40,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              ld_clr,
  input  logic [RATE_W-1:0] rate_idle,
  input  logic [CNT_W-1:0]  run_len,
  input  logic [LAT_W-1:0]  tmo_cycles,
  input  logic              start,
  output logic              stim_valid,
  output logic [DATA_W-1:0] stim_data,
  input  logic              resp_valid,
  output logic              busy,
  output logic              done,
  output logic              timeout,
  output logic [LVL_W-1:0]  fifo_level,
  output logic [CNT_W-1:0]  req_count,
  output logic [ACC_W-1:0]  lat_total,
  output logic [LAT_W-1:0]  avg_lat
);
  logic             rst_s1, rst_s2;
  logic             level_nz, rd_rst, rd_adv;
  logic             div_go, div_fin, busy_w;
  logic [LAT_W-1:0] div_quot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  slm_vec_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_s2),
    .wr_en    (ld_valid && !busy_w),
    .wr_data  (ld_data),
    .clr      (ld_clr && !busy_w),
    .rd_rst   (rd_rst),
    .rd_adv   (rd_adv),
    .rd_data  (stim_data),
    .level    (fifo_level),
    .level_nz (level_nz)
  );

  slm_sequencer #(.RATE_W(RATE_W), .CNT_W(CNT_W), .LAT_W(LAT_W), .ACC_W(ACC_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_s2),
    .start      (start),
    .rate_idle  (rate_idle),
    .run_len    (run_len),
    .tmo_cycles (tmo_cycles),
    .level_nz   (level_nz),
    .resp_valid (resp_valid),
    .div_fin    (div_fin),
    .div_quot   (div_quot),
    .issue      (stim_valid),
    .rd_rst     (rd_rst),
    .rd_adv     (rd_adv),
    .div_go     (div_go),
    .busy       (busy_w),
    .done       (done),
    .timeout    (timeout),
    .req_count  (req_count),
    .lat_total  (lat_total),
    .avg_lat    (avg_lat)
  );

  slm_avg_div #(.NUM_W(ACC_W), .DEN_W(CNT_W), .OUT_W(LAT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_s2),
    .go    (div_go),
    .num   (lat_total),
    .den   (req_count),
    .quot  (div_quot),
    .fin   (div_fin)
  );

  assign busy = busy_w;
endmodule

// File: rtl/stim_lat_mon_chk.sv
module stim_lat_mon_chk #(
  parameter int CNT_W = 16,
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stim_valid,
  input logic             busy,
  input logic             done,
  input logic             timeout,
  input logic [LVL_W-1:0] fifo_level,
  input logic [CNT_W-1:0] req_count
);
  // R4: the request strobe lasts one cycle and only inside a run
  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    stim_valid |=> !stim_valid);
  a_r4_strobe_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    stim_valid |-> busy);
  // R3: store contents cannot move while a run is active
  a_r3_level_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(fifo_level));
  // R7: answered count grows by at most one per cycle during a run
  a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (req_count == $past(req_count)) || (req_count == $past(req_count) + CNT_W'(1)));
  // R9: a timed-out run is stopped and issues nothing
  a_r9_stop_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (!busy && !stim_valid && !done));
  // R10: completion means idle with at least one answer
  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && req_count != '0));
  // R11: results hold while idle
  a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(req_count));
endmodule

bind stim_lat_mon stim_lat_mon_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .stim_valid (stim_valid),
  .busy       (busy),
  .done       (done),
  .timeout    (timeout),
  .fifo_level (fifo_level),
  .req_count  (req_count)
);

// File: tb/stim_lat_mon_tb.sv
module stim_lat_mon_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int RATE_W = 8;
  localparam int CNT_W  = 16;
  localparam int LAT_W  = 24;
  localparam int ACC_W  = 40;
  localparam int LVL_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ld_valid = 1'b0;
  logic [DATA_W-1:0] ld_data = '0;
  logic              ld_clr = 1'b0;
  logic [RATE_W-1:0] rate_idle = '0;
  logic [CNT_W-1:0]  run_len = '0;
  logic [LAT_W-1:0]  tmo_cycles = '0;
  logic              start = 1'b0;
  logic              resp_valid = 1'b0;
  logic              stim_valid, busy, done, timeout;
  logic [DATA_W-1:0] stim_data;
  logic [LVL_W-1:0]  fifo_level;
  logic [CNT_W-1:0]  req_count;
  logic [ACC_W-1:0]  lat_total;
  logic [LAT_W-1:0]  avg_lat;

  int errs = 0;
  int checks = 0;
  bit ended = 1'b0;
  logic [DATA_W-1:0] vec [DEPTH];
  int nvec = 0;

  always #10 clk = ~clk;

  stim_lat_mon #(.DATA_W(DATA_W), .DEPTH(DEPTH), .RATE_W(RATE_W), .CNT_W(CNT_W),
                 .LAT_W(LAT_W), .ACC_W(ACC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_data(ld_data), .ld_clr(ld_clr),
    .rate_idle(rate_idle), .run_len(run_len), .tmo_cycles(tmo_cycles), .start(start),
    .stim_valid(stim_valid), .stim_data(stim_data), .resp_valid(resp_valid), .busy(busy),
    .done(done), .timeout(timeout), .fifo_level(fifo_level), .req_count(req_count),
    .lat_total(lat_total), .avg_lat(avg_lat)
  );

  function automatic longint exp_avg(longint tot, longint cnt);
    return (cnt == 0) ? 0 : tot / cnt;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  task automatic load_vecs(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_data  = DATA_W'($urandom);
      vec[i]   = ld_data;
    end
    @(negedge clk);
    ld_valid = 1'b0;
    nvec = n;
  endtask

  task automatic run_case(input int rate, input int nreq, input bit poke);
    longint tot = 0;
    int     lat;
    bit     stray;
    int     lvl0 = int'(fifo_level);
    @(negedge clk);
    rate_idle  = RATE_W'(rate);
    run_len    = CNT_W'(nreq);
    tmo_cycles = LAT_W'(1000);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < nreq; i++) begin
      chk(stim_valid == 1'b1, (i == 0) ? "R4 issue after start" : "R6 issue spacing", stim_valid, 1);
      chk(stim_data == vec[i % nvec], "R5 replay order", stim_data, vec[i % nvec]);
      if (poke && i == 0) begin
        ld_valid = 1'b1;
        ld_clr   = 1'b1;
        ld_data  = 16'hdead;
      end
      lat = (i == 0) ? 1 : $urandom_range(1, 10);
      for (int k = 1; k <= lat; k++) begin
        @(negedge clk);
        ld_valid = 1'b0;
        ld_clr   = 1'b0;
        chk(stim_valid == 1'b0, "R6 no issue while outstanding", stim_valid, 0);
        resp_valid = (k == lat);
      end
      tot += lat;
      stray = ($urandom_range(0, 1) == 1);
      if (i == nreq - 1) begin
        @(negedge clk);
        resp_valid = stray;
        chk(req_count == CNT_W'(i + 1), "R7 count step", req_count, i + 1);
        chk(lat_total == ACC_W'(tot), "R7 latency total", lat_total, tot);
      end else begin
        for (int g = 0; g < rate; g++) begin
          @(negedge clk);
          chk(stim_valid == 1'b0, "R6 idle gap", stim_valid, 0);
          resp_valid = (g == 0) ? stray : 1'b0;
        end
        @(negedge clk);
        resp_valid = (rate == 0) ? stray : 1'b0;
        chk(req_count == CNT_W'(i + 1), "R7 R8 count step", req_count, i + 1);
        chk(lat_total == ACC_W'(tot), "R7 R8 latency total", lat_total, tot);
      end
    end
    @(negedge clk);
    resp_valid = 1'b0;
    for (int w = 0; w < ACC_W + 4 && !done; w++) @(negedge clk);
    chk(done == 1'b1, "R10 done raised", done, 1);
    chk(busy == 1'b0, "R10 busy dropped", busy, 0);
    chk(avg_lat == LAT_W'(exp_avg(tot, nreq)), "R10 average", avg_lat, exp_avg(tot, nreq));
    chk(req_count == CNT_W'(nreq), "R10 final count", req_count, nreq);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && avg_lat == LAT_W'(exp_avg(tot, nreq)), "R11 results hold", done, 1);
    chk(int'(fifo_level) == lvl0, "R3 store untouched in run", fifo_level, lvl0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!stim_valid && !busy && !done && !timeout, "R1 reset flags", {stim_valid, busy, done, timeout}, 0);
    chk(fifo_level == '0 && req_count == '0 && lat_total == '0 && avg_lat == '0,
        "R1 reset counters", fifo_level, 0);

    // R4: empty store start ignored
    start = 1'b1; run_len = 16'd3;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R4 start on empty store ignored", busy, 0);

    // R2: overfill then clear
    load_vecs(DEPTH + 1);
    chk(int'(fifo_level) == DEPTH, "R2 full store drops write", fifo_level, DEPTH);
    ld_clr = 1'b1;
    @(negedge clk);
    ld_clr = 1'b0;
    chk(fifo_level == '0, "R2 clear empties", fifo_level, 0);
    load_vecs(6);
    chk(fifo_level == LVL_W'(6), "R2 level after load", fifo_level, 6);

    // R4: zero run length ignored
    run_len = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b0, "R4 zero run length ignored", busy, 0);

    run_case(0, 9, 1'b1);
    run_case(3, 7, 1'b0);
    for (int c = 0; c < 3; c++) run_case($urandom_range(0, 5), $urandom_range(4, 13), 1'b1);

    // R9: answer at the limit accepted, then a missing answer
    @(negedge clk);
    rate_idle = 8'd2; run_len = 16'd3; tmo_cycles = 24'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0 && timeout == 1'b0, "R11 start clears flags", done, 0);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      resp_valid = (k == 5);
    end
    @(negedge clk);
    resp_valid = 1'b0;
    chk(req_count == 16'd1 && timeout == 1'b0, "R9 answer at limit accepted", req_count, 1);
    repeat (2) @(negedge clk);
    chk(stim_valid == 1'b1, "R6 issue after two idle cycles", stim_valid, 1);
    repeat (5) @(negedge clk);
    chk(timeout == 1'b0 && busy == 1'b1, "R9 not yet timed out", timeout, 0);
    @(negedge clk);
    chk(timeout == 1'b1, "R9 timeout raised", timeout, 1);
    chk(busy == 1'b0 && done == 1'b0, "R9 run stopped", busy, 0);
    chk(lat_total == 40'd5, "R9 total keeps accepted answer", lat_total, 5);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      resp_valid = (k == 2);
      if (stim_valid) chk(1'b0, "R9 no issue after stop", stim_valid, 0);
    end
    chk(req_count == 16'd1, "R8 answer while idle ignored", req_count, 1);
    finish_run();
  end

  initial begin
    for (int n = 0; n < 150000; n++) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end
endmodule